// File: doc/BRIEF.md
# SDRAM Timing Word Generator

This block turns a memory device's timing figures, given in nanoseconds, into two packed 32-bit words that a synchronous DRAM controller takes as its configuration: a timing word holding six small encoded fields and a refresh-interval word. The inputs are the bus clock frequency in hertz, the CAS latency in clocks, the precharge, row-cycle and RAS-to-CAS delays, an optional refresh-cycle time, the number of row address bits and the refresh period in milliseconds.

A pulse on `start` captures every input. When the `use_computed` strap is high, the block works through eight unsigned integer divisions on one shared divider that settles one quotient bit per clock. It first derives the bus period in tenths of a nanosecond, then converts each delay into a clock count with an extra clock always added. Each count is clamped into its field's legal range, and a field-specific fallback code is used when the count falls outside it. When the strap is low, one of two fixed word pairs is chosen by frequency. `done` pulses once when both words are valid, and the words then hold until the next job finishes.

Top module: `sdram_timing_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both output words are 0.
- R2: `start` taken while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, in the same cycle that both words take their new values, and `busy` is low in that cycle. The words do not change at any other time.
- R3: `start` while `busy` is high is ignored: the finished words belong to the inputs captured by the first `start`.
- R4: Default mode (`use_computed`=0) with `freq_hz` above 100000000 gives timing word 0x01074015 and refresh word 0x07F00000.
- R5: Default mode with `freq_hz` at or below 100000000 gives timing word 0x0086400D and refresh word 0x05F00000.
- R6: In computed mode, P = 1000000000 / (freq_hz/10) is the bus period in tenths of a ns. A delay of N ns becomes the clock count (10*N + P) / P. All divisions truncate and use 64-bit unsigned arithmetic.
- R7: Timing word bits 24:23 hold the CAS code: 1 when CL < 2, 3 when CL > 4, otherwise CL-1.
- R8: Three 2-bit fields hold count-1 for counts 2 to 4 and hold 3 for any other count. Bits 19:18 are converted from tRP. Bits 17:16 are converted from tRC-tRCD-tRP, taken modulo 2^16. Bits 1:0 are converted from tRCD.
- R9: Timing word bits 15:14 (the leadoff field, converted from 0 ns and so always one clock) hold 1 in computed mode.
- R10: Timing word bits 4:2 hold count-4 for counts 4 to 10 and hold 6 for any other count. The count is converted from tRFC when `trfc_valid` is 1 and from tRC when it is 0. All timing word bits not named in R7 to R10 are 0.
- R11: In computed mode, the refresh word is (Q & 0x3FF8) << 16, where Q = (((refresh_ms*1000000) >> row_bits) * (freq_hz/1000)) / 1000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job and capture all inputs (ignored while busy) |
| use_computed | input | 1 | Strap: 1 computes the words, 0 selects fixed defaults |
| freq_hz | input | 32 | Bus clock frequency in Hz |
| cas_clk | input | 4 | CAS latency in clocks |
| trp_ns | input | 16 | Precharge time, ns |
| trc_ns | input | 16 | Row cycle time, ns |
| trcd_ns | input | 16 | RAS-to-CAS delay, ns |
| trfc_ns | input | 16 | Refresh cycle time, ns |
| trfc_valid | input | 1 | 1 when `trfc_ns` is supplied |
| row_bits | input | 5 | Number of row address bits |
| refresh_ms | input | 16 | Refresh period in ms |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: words are valid |
| timing_word | output | 32 | Packed timing register word |
| refresh_word | output | 32 | Packed refresh interval word |

## Verification
The bench targets the clamp edges: counts that land exactly on 1, 2, 4, 5, 10 and 11 clocks. A design with an off-by-one range test would emit count-1 where the fallback is due, or the fallback where a valid code is due. The bench also sweeps CAS latencies on both sides of the 2 to 4 window and toggles `trfc_valid`. A design that swapped the tRFC/tRC choice, or dropped the forced extra clock, would therefore shift the refresh-to-activate code. It probes the default-mode boundary at exactly 100 MHz, where a `>=` comparison would return the faster word pair. It also fires a second `start` mid-job: a design that recaptured inputs would finish with the second job's words.

// File: rtl/sdtc_pkg.sv
package sdtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FINISH} sdtc_state_e;

  localparam int NSTEP = 8;
  // step order: freq/10, period, precharge, cmd-to-pre, refresh-to-act, ras-to-cas, freq/1000, refresh
  localparam int S_F10  = 0;
  localparam int S_PER  = 1;
  localparam int S_PRE  = 2;
  localparam int S_CTP  = 3;
  localparam int S_RFA  = 4;
  localparam int S_RCD  = 5;
  localparam int S_FK   = 6;
  localparam int S_RFSH = 7;

  localparam logic [31:0] DEF_TW_FAST = 32'h0107_4015;
  localparam logic [31:0] DEF_RW_FAST = 32'h07F0_0000;
  localparam logic [31:0] DEF_TW_SLOW = 32'h0086_400D;
  localparam logic [31:0] DEF_RW_SLOW = 32'h05F0_0000;
  localparam logic [31:0] FAST_LIMIT  = 32'd100_000_000;
  localparam logic [1:0]  LEADOFF_CODE = 2'd1;
endpackage

// File: rtl/sdtc_seq_div.sv
module sdtc_seq_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial;

  assign trial = {rem_q, quo[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        quo   <= num;
        den_q <= den;
        rem_q <= '0;
        cnt_q <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, den_q}) begin
          rem_q <= W'(trial - {1'b0, den_q});
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo   <= {quo[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6
  div_done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R6
  div_count_live_chk: assert property (@(posedge clk) disable iff (rst) busy |-> cnt_q != '0);
endmodule

// File: rtl/sdtc_field_enc.sv
module sdtc_field_enc #(
  parameter int CW       = 64,
  parameter int OW       = 2,
  parameter int LO       = 2,
  parameter int HI       = 4,
  parameter int BIAS     = 1,
  parameter int FALLBACK = 3
) (
  input  logic [CW-1:0] clocks,
  output logic [OW-1:0] code
);
  localparam logic [CW-1:0] LO_V = CW'(LO);
  localparam logic [CW-1:0] HI_V = CW'(HI);
  localparam logic [CW-1:0] BIAS_V = CW'(BIAS);

  logic [CW-1:0] biased;
  assign biased = clocks - BIAS_V;

  always_comb begin
    if (clocks >= LO_V && clocks <= HI_V) code = biased[OW-1:0];
    else                                   code = OW'(FALLBACK);
  end
endmodule

// File: rtl/sdram_timing_calc.sv
module sdram_timing_calc #(
  parameter int FREQ_W = 32,
  parameter int CL_W   = 4,
  parameter int NS_W   = 16,
  parameter int ROW_W  = 5,
  parameter int MS_W   = 16,
  parameter int DW     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              use_computed,
  input  logic [FREQ_W-1:0] freq_hz,
  input  logic [CL_W-1:0]   cas_clk,
  input  logic [NS_W-1:0]   trp_ns,
  input  logic [NS_W-1:0]   trc_ns,
  input  logic [NS_W-1:0]   trcd_ns,
  input  logic [NS_W-1:0]   trfc_ns,
  input  logic              trfc_valid,
  input  logic [ROW_W-1:0]  row_bits,
  input  logic [MS_W-1:0]   refresh_ms,
  output logic              busy,
  output logic              done,
  output logic [31:0]       timing_word,
  output logic [31:0]       refresh_word
);
  import sdtc_pkg::*;

  localparam int STEP_W = $clog2(NSTEP);
  localparam logic [DW-1:0] K10   = DW'(10);
  localparam logic [DW-1:0] K1K   = DW'(1000);
  localparam logic [DW-1:0] K1M   = DW'(1000000);
  localparam logic [DW-1:0] K1G   = DW'(1000000000);
  localparam logic [DW-1:0] RMASK = DW'(16'h3FF8);

  sdtc_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [DW-1:0]     res_q [NSTEP];

  logic [FREQ_W-1:0] f_q;
  logic [CL_W-1:0]   cl_q;
  logic [NS_W-1:0]   trp_q, trc_q, trcd_q, trfc_q;
  logic              rfcv_q, comp_q;
  logic [ROW_W-1:0]  rows_q;
  logic [MS_W-1:0]   ms_q;

  logic [NS_W-1:0] ns_sel;
  logic [DW-1:0]   op_num, op_den;
  logic            div_go, div_busy, div_done;
  logic [DW-1:0]   div_quo;

  // operand selection for the current step
  always_comb begin
    ns_sel = '0;
    op_num = '0;
    op_den = res_q[S_PER];
    case (int'(step_q))
      S_F10:  begin op_num = DW'(f_q); op_den = K10; end
      S_PER:  begin op_num = K1G; op_den = res_q[S_F10]; end
      S_FK:   begin op_num = DW'(f_q); op_den = K1K; end
      S_RFSH: begin
        op_num = ((DW'(ms_q) * K1M) >> rows_q) * res_q[S_FK];
        op_den = K1M;
      end
      default: begin
        case (int'(step_q))
          S_PRE:   ns_sel = trp_q;
          S_CTP:   ns_sel = trc_q - trcd_q - trp_q;
          S_RFA:   ns_sel = rfcv_q ? trfc_q : trc_q;
          default: ns_sel = trcd_q;
        endcase
        op_num = DW'(ns_sel) * K10 + res_q[S_PER];
      end
    endcase
  end

  assign div_go = (state_q == ST_ISSUE);

  sdtc_seq_div #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(op_num), .den(op_den),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  logic [1:0] pre_code, ctp_code, rcd_code, cas_code;
  logic [2:0] rfa_code;

  sdtc_field_enc #(.CW(DW), .OW(2), .LO(2), .HI(4),  .BIAS(1), .FALLBACK(3))
    u_pre (.clocks(res_q[S_PRE]), .code(pre_code));
  sdtc_field_enc #(.CW(DW), .OW(2), .LO(2), .HI(4),  .BIAS(1), .FALLBACK(3))
    u_ctp (.clocks(res_q[S_CTP]), .code(ctp_code));
  sdtc_field_enc #(.CW(DW), .OW(3), .LO(4), .HI(10), .BIAS(4), .FALLBACK(6))
    u_rfa (.clocks(res_q[S_RFA]), .code(rfa_code));
  sdtc_field_enc #(.CW(DW), .OW(2), .LO(2), .HI(4),  .BIAS(1), .FALLBACK(3))
    u_rcd (.clocks(res_q[S_RCD]), .code(rcd_code));

  always_comb begin
    if (cl_q < CL_W'(2))      cas_code = 2'd1;
    else if (cl_q > CL_W'(4)) cas_code = 2'd3;
    else                      cas_code = 2'(cl_q - CL_W'(1));
  end

  logic [31:0] tw_calc, rw_calc;
  assign tw_calc = (32'(cas_code) << 23) | (32'(pre_code) << 18) | (32'(ctp_code) << 16)
                 | (32'(LEADOFF_CODE) << 14) | (32'(rfa_code) << 2) | 32'(rcd_code);
  assign rw_calc = 32'((res_q[S_RFSH] & RMASK) << 16);

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done    <= 1'b0;
      timing_word  <= '0;
      refresh_word <= '0;
      f_q <= '0; cl_q <= '0; trp_q <= '0; trc_q <= '0; trcd_q <= '0; trfc_q <= '0;
      rfcv_q <= 1'b0; comp_q <= 1'b0; rows_q <= '0; ms_q <= '0;
      for (int i = 0; i < NSTEP; i++) res_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          f_q <= freq_hz; cl_q <= cas_clk; trp_q <= trp_ns; trc_q <= trc_ns;
          trcd_q <= trcd_ns; trfc_q <= trfc_ns; rfcv_q <= trfc_valid;
          rows_q <= row_bits; ms_q <= refresh_ms; comp_q <= use_computed;
          step_q  <= '0;
          state_q <= use_computed ? ST_ISSUE : ST_FINISH;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          res_q[step_q] <= div_quo;
          if (int'(step_q) == NSTEP - 1) state_q <= ST_FINISH;
          else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        default: begin
          if (comp_q) begin
            timing_word  <= tw_calc;
            refresh_word <= rw_calc;
          end else if (f_q > FREQ_W'(FAST_LIMIT)) begin
            timing_word  <= DEF_TW_FAST;
            refresh_word <= DEF_RW_FAST;
          end else begin
            timing_word  <= DEF_TW_SLOW;
            refresh_word <= DEF_RW_SLOW;
          end
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  words_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(timing_word) && $stable(refresh_word)));
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R3
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(f_q) && $stable(trc_q) && $stable(comp_q)));
  // R9
  leadoff_chk: assert property (@(posedge clk) disable iff (rst)
    (done && comp_q) |-> timing_word[15:14] == 2'b01);
  // R10
  rfa_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && comp_q) |-> timing_word[4:2] <= 3'd6);
  // R6
  div_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !div_busy);
endmodule

// File: tb/sdram_timing_calc_test.sv
module sdram_timing_calc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        use_computed = 1'b0;
  logic [31:0] freq_hz = '0;
  logic [3:0]  cas_clk = '0;
  logic [15:0] trp_ns = '0, trc_ns = '0, trcd_ns = '0, trfc_ns = '0;
  logic        trfc_valid = 1'b0;
  logic [4:0]  row_bits = '0;
  logic [15:0] refresh_ms = '0;
  logic        busy, done;
  logic [31:0] timing_word, refresh_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sdram_timing_calc uut (
    .clk(clk), .rst(rst), .start(start), .use_computed(use_computed),
    .freq_hz(freq_hz), .cas_clk(cas_clk), .trp_ns(trp_ns), .trc_ns(trc_ns),
    .trcd_ns(trcd_ns), .trfc_ns(trfc_ns), .trfc_valid(trfc_valid),
    .row_bits(row_bits), .refresh_ms(refresh_ms),
    .busy(busy), .done(done), .timing_word(timing_word), .refresh_word(refresh_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // reference model
  function automatic longint unsigned period10(input logic [31:0] f);
    longint unsigned f10 = longint'(f) / 10;
    return 64'd1000000000 / f10;
  endfunction

  function automatic longint unsigned to_clk(input logic [15:0] ns, input logic [31:0] f);
    longint unsigned p = period10(f);
    return (longint'(ns) * 10 + p) / p;
  endfunction

  function automatic logic [31:0] enc(input longint unsigned c, input int lo, input int hi,
                                      input int bias, input int fb);
    if (c >= longint'(lo) && c <= longint'(hi)) return 32'(c - longint'(bias));
    return 32'(fb);
  endfunction

  function automatic logic [31:0] cas_enc(input logic [3:0] cl);
    if (cl < 2) return 32'd1;
    if (cl > 4) return 32'd3;
    return 32'(cl - 1);
  endfunction

  logic [31:0] e_tw, e_rw;

  task automatic model();
    logic [15:0] ctp;
    longint unsigned q;
    if (!use_computed) begin
      e_tw = (freq_hz > 32'd100000000) ? 32'h01074015 : 32'h0086400D;
      e_rw = (freq_hz > 32'd100000000) ? 32'h07F00000 : 32'h05F00000;
    end else begin
      ctp = trc_ns - trcd_ns - trp_ns;
      e_tw = (cas_enc(cas_clk) << 23)
           | (enc(to_clk(trp_ns, freq_hz), 2, 4, 1, 3) << 18)
           | (enc(to_clk(ctp, freq_hz), 2, 4, 1, 3) << 16)
           | (32'd1 << 14)
           | (enc(to_clk(trfc_valid ? trfc_ns : trc_ns, freq_hz), 4, 10, 4, 6) << 2)
           | enc(to_clk(trcd_ns, freq_hz), 2, 4, 1, 3);
      q = (((longint'(refresh_ms) * 64'd1000000) >> row_bits) * (longint'(freq_hz) / 1000)) / 64'd1000000;
      e_rw = 32'((q & 64'h3FF8) << 16);
    end
  endtask

  // runs one job; when inject is set a second start with other values arrives mid-job
  task automatic run_job(input bit inject);
    bit got;
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    if (inject) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      freq_hz = freq_hz + 32'd7_000_000;
      trp_ns = trp_ns + 16'd30;
      use_computed = ~use_computed;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    check("R2 done seen", {31'd0, got}, 32'd1);
    if (got) begin
      check("R2 busy low at done", {31'd0, busy}, 32'd0);
      if (inject) begin
        check("R3 timing word kept", timing_word, e_tw);
        check("R3 refresh word kept", refresh_word, e_rw);
      end else if (!use_computed) begin
        check(freq_hz > 32'd100000000 ? "R4 timing default" : "R5 timing default", timing_word, e_tw);
        check(freq_hz > 32'd100000000 ? "R4 refresh default" : "R5 refresh default", refresh_word, e_rw);
      end else begin
        check("R7 cas field", {30'd0, timing_word[24:23]}, {30'd0, e_tw[24:23]});
        check("R6/R8 precharge field", {30'd0, timing_word[19:18]}, {30'd0, e_tw[19:18]});
        check("R6/R8 cmd-to-precharge field", {30'd0, timing_word[17:16]}, {30'd0, e_tw[17:16]});
        check("R6/R8 ras-to-cas field", {30'd0, timing_word[1:0]}, {30'd0, e_tw[1:0]});
        check("R9 leadoff field", {30'd0, timing_word[15:14]}, 32'd1);
        check("R10 refresh-to-activate field", {29'd0, timing_word[4:2]}, {29'd0, e_tw[4:2]});
        check("R10 whole timing word", timing_word, e_tw);
        check("R11 refresh word", refresh_word, e_rw);
      end
      @(negedge clk);
      check("R2 done one cycle", {31'd0, done}, 32'd0);
      repeat (3) @(negedge clk);
      check("R2 timing held", timing_word, e_tw);
      check("R2 refresh held", refresh_word, e_rw);
    end
  endtask

  task automatic set_job(input bit comp, input logic [31:0] f, input logic [3:0] cl,
                         input logic [15:0] rp, input logic [15:0] rc, input logic [15:0] rcd,
                         input logic [15:0] rfc, input bit rfcv, input logic [4:0] rows,
                         input logic [15:0] ms);
    use_computed = comp; freq_hz = f; cas_clk = cl; trp_ns = rp; trc_ns = rc;
    trcd_ns = rcd; trfc_ns = rfc; trfc_valid = rfcv; row_bits = rows; refresh_ms = ms;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 timing word", timing_word, 32'd0);
    check("R1 refresh word", refresh_word, 32'd0);
    rst = 1'b0;

    // R4 / R5 defaults around the 100 MHz boundary
    set_job(1'b0, 32'd100000000, 4'd2, 16'd20, 16'd65, 16'd20, 16'd0, 1'b0, 5'd13, 16'd64);
    run_job(1'b0);
    set_job(1'b0, 32'd100000001, 4'd2, 16'd20, 16'd65, 16'd20, 16'd0, 1'b0, 5'd13, 16'd64);
    run_job(1'b0);
    set_job(1'b0, 32'd133000000, 4'd3, 16'd20, 16'd65, 16'd20, 16'd0, 1'b0, 5'd13, 16'd64);
    run_job(1'b0);

    // directed computed cases: typical part, clamp edges, CAS extremes, tRFC choice
    set_job(1'b1, 32'd100000000, 4'd2, 16'd20, 16'd65, 16'd20, 16'd0, 1'b0, 5'd13, 16'd64);
    run_job(1'b0);
    // 10 ns period: 5 ns -> 1 clk, 30 ns -> 4 clk, 40 ns -> 5 clk
    set_job(1'b1, 32'd100000000, 4'd1, 16'd5, 16'd75, 16'd30, 16'd100, 1'b1, 5'd12, 16'd32);
    run_job(1'b0);
    set_job(1'b1, 32'd100000000, 4'd5, 16'd40, 16'd110, 16'd10, 16'd30, 1'b1, 5'd11, 16'd16);
    run_job(1'b0);
    set_job(1'b1, 32'd100000000, 4'd4, 16'd19, 16'd109, 16'd29, 16'd30, 1'b0, 5'd14, 16'd64);
    run_job(1'b0);
    set_job(1'b1, 32'd133000000, 4'd0, 16'd15, 16'd60, 16'd15, 16'd75, 1'b1, 5'd13, 16'd64);
    run_job(1'b0);

    // R3 second start while busy
    set_job(1'b1, 32'd66000000, 4'd3, 16'd24, 16'd80, 16'd22, 16'd0, 1'b0, 5'd12, 16'd64);
    run_job(1'b1);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [15:0] rp, rcd;
      rp  = 16'(5 + $urandom_range(0, 55));
      rcd = 16'(5 + $urandom_range(0, 55));
      set_job(1'($urandom_range(0, 5) != 0), 32'(20000000 + $urandom_range(0, 180000000)),
              4'($urandom_range(0, 7)), rp, 16'(rp + rcd + 16'($urandom_range(0, 80))), rcd,
              16'(20 + $urandom_range(0, 100)), 1'($urandom_range(0, 1)),
              5'(10 + $urandom_range(0, 4)), 16'(16 + $urandom_range(0, 112)));
      run_job(1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule